// File: doc/BRIEF.md
# SPI Slave Hold Pause Controller

This block sits in front of the serial shifter of an SPI slave and decides when the slave is paused by its active-low hold pin. The block samples the serial clock, chip select, hold pin and the quad-mode setting in the system clock domain. From these samples it keeps a registered hold-active flag. A pause can start only while the slave is selected and quad mode is off. Entry and exit take effect only while the serial clock is low. If the serial clock is already low when the hold pin moves, the change takes effect at once. If the clock is high, the change waits until the clock next falls.

While the pause lasts, the block withholds the capture strobe (serial clock rising) and the launch strobe (serial clock falling) that drive the front-end shifter. It also removes the output enable of the data-out driver. A half-received command or a part-filled page buffer therefore stays frozen, and the transfer resumes at the same bit once the pause ends. When chip select rises, the pause ends and a one-cycle clear pulse tells the front end to drop its partial state.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, hold_active, sdo_oe, sample_en, drive_en and fe_clear are all 0.
- R2: With chip select low, quad mode off and the serial clock low, a low hold pin makes hold_active 1.
- R3: If the hold pin goes low while the serial clock is high, hold_active stays 0 until the serial clock falls, and then becomes 1.
- R4: If the hold pin goes high while the serial clock is low, hold_active returns to 0 at once.
- R5: If the hold pin goes high while the serial clock is high, hold_active stays 1 until the serial clock falls.
- R6: While hold_active is 1, sdo_oe is 0 and no sample_en or drive_en pulse appears for any serial clock toggling. After the pause ends, the pulse counts continue from where they stopped.
- R7: While quad_mode is 1, hold_active is 0 whatever the hold pin does. Raising quad_mode during a pause ends the pause.
- R8: While chip select is high, hold_active, sdo_oe, sample_en and drive_en are 0. Each rise of chip select gives exactly one fe_clear pulse, one system clock cycle long.
- R9: Every output is a register output. Each output reacts SYNC_STAGES+1 system clock cycles after a pin change (3 cycles with the defaults).
- R10: While the slave is selected and not paused, each serial clock rise gives one sample_en pulse and each serial clock fall gives one drive_en pulse. Each pulse lasts one system clock cycle.
- R11: sdo_oe is 1 exactly when chip select is low and hold_active is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock pin (asynchronous) |
| spi_cs_n | input | 1 | Active-low chip select pin |
| spi_hold_n | input | 1 | Active-low hold pin |
| quad_mode | input | 1 | Quad mode setting; 1 disables the hold function |
| hold_active | output | 1 | Registered pause flag |
| sample_en | output | 1 | One-cycle capture strobe for the shifter on a serial clock rise |
| drive_en | output | 1 | One-cycle launch strobe for the shifter on a serial clock fall |
| sdo_oe | output | 1 | Output enable of the data-out driver |
| fe_clear | output | 1 | One-cycle clear of the front-end state on a chip select rise |

## Verification
A wrong hold state shows up at the ports within SYNC_STAGES+1 system cycles of the pin change that should have moved it. In that cycle, hold_active and sdo_oe disagree with the expected levels. The next serial clock toggle then adds a strobe that should not exist, or fails to add one. The strobes are counted across each pause, so a single strobe that leaks through or goes missing shows up as a count that is off by one after the pause ends. The deferred entry and exit are checked while the serial clock is still high and again after it falls, so an early change and a late change are both caught.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

    typedef struct packed {
        logic hold;
        logic sclk;
        logic cs_n;
        logic quad;
        logic sample_en;
        logic drive_en;
        logic fe_clear;
    } hold_state_t;

    localparam hold_state_t HOLD_STATE_RESET = '{
        hold:      1'b0,
        sclk:      1'b0,
        cs_n:      1'b1,
        quad:      1'b0,
        sample_en: 1'b0,
        drive_en:  1'b0,
        fe_clear:  1'b0
    };

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_chain
            if (g == 0) begin : g_first
                assign stage_d[g] = async_i;
            end else begin : g_rest
                assign stage_d[g] = stage_q[g-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_hold_core.sv
module spi_hold_core
    import spi_hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic s_sclk,
    input  logic s_cs_n,
    input  logic s_hold_n,
    input  logic s_quad,
    output logic hold_active,
    output logic sample_en,
    output logic drive_en,
    output logic sdo_oe,
    output logic fe_clear
);

    hold_state_t st_d, st_q;
    logic        allowed;

    always_comb begin
        st_d      = st_q;
        allowed   = !s_cs_n && !s_quad;

        st_d.sclk = s_sclk;
        st_d.cs_n = s_cs_n;
        st_d.quad = s_quad;

        // Pause changes only while the serial clock is low; a change requested
        // with the clock high waits for the clock to fall.
        if (!allowed)     st_d.hold = 1'b0;
        else if (!s_sclk) st_d.hold = !s_hold_n;
        else              st_d.hold = st_q.hold;

        st_d.sample_en = !s_cs_n && s_sclk && !st_q.sclk && !st_d.hold;
        st_d.drive_en  = !s_cs_n && !s_sclk && st_q.sclk && !st_d.hold;
        st_d.fe_clear  = s_cs_n && !st_q.cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HOLD_STATE_RESET;
        else        st_q <= st_d;
    end

    assign hold_active = st_q.hold;
    assign sample_en   = st_q.sample_en;
    assign drive_en    = st_q.drive_en;
    assign fe_clear    = st_q.fe_clear;
    assign sdo_oe      = !st_q.cs_n && !st_q.hold;

    assert_entry_clk_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.hold) |-> (!st_q.sclk && !st_q.cs_n && !st_q.quad));

    // R4 / R5: a normal exit happens only with the serial clock low
    assert_exit_clk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.hold) |-> (!st_q.sclk || st_q.cs_n || st_q.quad));

    assert_no_strobe_in_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hold |-> (!st_q.sample_en && !st_q.drive_en));

    assert_quad_blocks_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.quad |-> !st_q.hold);

    assert_deselect_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cs_n |-> (!st_q.hold && !st_q.sample_en && !st_q.drive_en));

    assert_clear_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fe_clear |=> !st_q.fe_clear);

    assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.sample_en && st_q.drive_en));

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_hold_n,
    input  logic quad_mode,
    output logic hold_active,
    output logic sample_en,
    output logic drive_en,
    output logic sdo_oe,
    output logic fe_clear
);

    localparam int PIN_COUNT = 4;
    // Idle levels: sclk 0, cs_n 1, hold_n 1, quad 0 (order sclk, cs_n, hold_n, quad)
    localparam logic [PIN_COUNT-1:0] PIN_IDLE = 4'b0110;

    logic [PIN_COUNT-1:0] pins_async;
    logic [PIN_COUNT-1:0] pins_sync;

    assign pins_async = {spi_sclk, spi_cs_n, spi_hold_n, quad_mode};

    spi_hold_sync #(
        .WIDTH  (PIN_COUNT),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_IDLE)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pins_async),
        .sync_o (pins_sync)
    );

    spi_hold_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_sclk     (pins_sync[3]),
        .s_cs_n     (pins_sync[2]),
        .s_hold_n   (pins_sync[1]),
        .s_quad     (pins_sync[0]),
        .hold_active(hold_active),
        .sample_en  (sample_en),
        .drive_en   (drive_en),
        .sdo_oe     (sdo_oe),
        .fe_clear   (fe_clear)
    );

    assert_oe_matches_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> !hold_active);

endmodule

// File: tb/spi_hold_ctrl_test.sv
module spi_hold_ctrl_test;

    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 1;
    localparam int NVEC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, hold_n = 1'b1, quad = 1'b0;
    logic hold_active, sample_en, drive_en, sdo_oe, fe_clear;

    int n_cmp = 0, n_bad = 0;
    int cnt_rise = 0, cnt_fall = 0, cnt_clr = 0;

    always #4 clk = ~clk;

    spi_hold_ctrl #(.SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_hold_n(hold_n), .quad_mode(quad), .hold_active(hold_active),
        .sample_en(sample_en), .drive_en(drive_en), .sdo_oe(sdo_oe),
        .fe_clear(fe_clear)
    );

    always @(negedge clk) begin
        if (sample_en) cnt_rise++;
        if (drive_en)  cnt_fall++;
        if (fe_clear)  cnt_clr++;
    end

    // {cs_n, sclk, hold_n, quad, exp_hold, exp_oe}
    localparam logic [5:0] VEC [NVEC] = '{
        6'b101000,  // deselected                          R8
        6'b001001,  // selected, idle                      R11
        6'b011001,  // clock high
        6'b010001,  // hold low, clock high: deferred       R3
        6'b000010,  // clock falls: pause starts            R3
        6'b010010,  // clock high in pause                  R6
        6'b011010,  // hold high, clock high: deferred      R5
        6'b001001,  // clock falls: pause ends              R5
        6'b000010,  // hold low, clock low: immediate       R2
        6'b001001,  // hold high, clock low: immediate      R4
        6'b000101,  // quad set: no pause                   R7
        6'b000010,  // quad cleared: pause                  R2
        6'b000101,  // quad set during pause ends it        R7
        6'b000010,  // pause again
        6'b100000,  // cs high ends pause                   R8
        6'b101000   // deselected idle
    };

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (LAT) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic burst(input int n);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1; repeat (LAT + 2) @(negedge clk);
            sclk = 1'b0; repeat (LAT + 2) @(negedge clk);
        end
    endtask

    initial begin
        #1_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int r0, f0, c0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", hold_active, 1'b0, "hold_active");
        check("R1", sdo_oe, 1'b0, "sdo_oe");
        check("R1", sample_en | drive_en | fe_clear, 1'b0, "strobes");
        rst_n = 1'b1;
        settle();

        for (int v = 0; v < NVEC; v++) begin
            {cs_n, sclk, hold_n, quad} = VEC[v][5:2];
            // R9: unchanged one cycle before the latency expires (vector 8 starts a pause)
            if (v == 8) begin
                repeat (LAT - 1) @(posedge clk);
                @(negedge clk);
                check("R9", hold_active, 1'b0, "hold before latency");
                @(negedge clk);
                check("R9", hold_active, 1'b1, "hold at latency");
            end else begin
                settle();
            end
            check("R2-vec", hold_active, VEC[v][1], $sformatf("hold_active vec%0d", v));
            check("R11", sdo_oe, VEC[v][0], $sformatf("sdo_oe vec%0d", v));
        end

        // R8 / R10: deselected toggling gives no strobes
        cs_n = 1'b1; hold_n = 1'b1; quad = 1'b0; sclk = 1'b0; settle();
        r0 = cnt_rise; f0 = cnt_fall;
        burst(2);
        check_int("R8", cnt_rise - r0, 0, "rises while deselected");
        check_int("R8", cnt_fall - f0, 0, "falls while deselected");

        // R10: selected, strobe per edge
        cs_n = 1'b0; settle();
        r0 = cnt_rise; f0 = cnt_fall;
        burst(3);
        check_int("R10", cnt_rise - r0, 3, "sample_en count");
        check_int("R10", cnt_fall - f0, 3, "drive_en count");

        // R6: pause freezes strobes, resumes afterwards
        hold_n = 1'b0; settle();
        check("R6", hold_active, 1'b1, "hold entered");
        r0 = cnt_rise; f0 = cnt_fall;
        burst(4);
        check_int("R6", cnt_rise - r0, 0, "sample_en in pause");
        check_int("R6", cnt_fall - f0, 0, "drive_en in pause");
        check("R6", sdo_oe, 1'b0, "sdo_oe in pause");
        hold_n = 1'b1; settle();
        burst(2);
        check_int("R6", cnt_rise - r0, 2, "sample_en after resume");
        check_int("R6", cnt_fall - f0, 2, "drive_en after resume");

        // R8: one clear pulse per chip select rise, also from inside a pause
        hold_n = 1'b0; settle();
        c0 = cnt_clr;
        cs_n = 1'b1; settle(); repeat (4) @(negedge clk);
        check_int("R8", cnt_clr - c0, 1, "fe_clear from pause");
        check("R8", hold_active, 1'b0, "hold after deselect");
        hold_n = 1'b1; cs_n = 1'b0; settle();
        cs_n = 1'b1; settle(); repeat (4) @(negedge clk);
        check_int("R8", cnt_clr - c0, 2, "fe_clear second rise");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule